// File: doc/BRIEF.md
# Multi-Lane Bit Buffer Refill Unit

This block holds the input bits of many independent sub-streams, one per lane, for a parallel entropy decoder. Each lane owns a 64-bit bit buffer and a count of how many of its low bits are valid. The sub-stream words are not laid out at fixed strides in memory. They are interleaved in the order in which lanes run short of bits. A refill step therefore finds every lane holding fewer than 32 valid bits. It gives each such lane the next free word after a shared input pointer, ranked by lane index, then appends the fetched words and moves the pointer past all of them.

A round has two steps. First a refill (`refill_go`) is issued, so that every lane shows at least 32 valid bits in its window. The decoders outside the block then work out how many bits each lane used, and a consume step (`consume_go`) shifts those bits out of every active lane. A lane that is asked to drop more bits than it holds flags an underflow, and its state is left untouched. Symbol decoding is done outside this block.

Top module: `lane_refill_unit`

## Requirements
- R1: After reset every lane has a count of 0 and a window of 0, the pointer is 0, no read is enabled and no underflow is flagged.
- R2: While `refill_go` is high, `rd_en_o[i]` is 1 exactly for the lanes whose valid count is below 32.
- R3: While `refill_go` is high, a requesting lane i reads address `ptr_o` plus the number of requesting lanes with an index below i. Lane i's address is field i of `rd_addr_o`, ADDR_W bits starting at bit i*ADDR_W.
- R4: After a refill step the pointer has advanced by the number of requesting lanes. In any other cycle it holds its value.
- R5: A refilling lane places its 32-bit word at bit position equal to its old count and adds 32 to the count. Lanes that do not request keep their state.
- R6: On a consume step (`consume_go` high, `refill_go` low), each active lane whose request n (field i of `consume_n_i`, 6 bits) is at most its count shifts its buffer right by n bits, filling with zeros, and subtracts n from its count.
- R7: On a consume step, a lane whose `lane_active_i` bit is 0 keeps its buffer and count, whatever its request.
- R8: An active lane asked to consume more than its count keeps its state and raises its `underflow_o` bit in the next cycle for one cycle only.
- R9: When `refill_go` and `consume_go` are high in the same cycle, only the refill takes place and all consume requests are ignored.
- R10: The first refill after reset reads the 32 consecutive addresses 0 to 31, lane i reading address i, and leaves the pointer at 32.
- R11: `win_o` field i (32 bits) is the low 32 bits of lane i's buffer, and `cnt_o` field i (7 bits) is its valid count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refill_go | input | 1 | Perform the refill step this cycle |
| consume_go | input | 1 | Perform the consume step this cycle |
| lane_active_i | input | LANES | Lanes taking part in the consume step |
| consume_n_i | input | LANES*6 | Bits to drop per lane |
| rd_data_i | input | LANES*32 | Word returned for each lane's read address |
| rd_en_o | output | LANES | Lanes reading a word this cycle |
| rd_addr_o | output | LANES*ADDR_W | Word address per lane |
| ptr_o | output | ADDR_W | Shared input word pointer |
| win_o | output | LANES*32 | Low 32 bits of each lane buffer |
| cnt_o | output | LANES*7 | Valid bit count per lane |
| underflow_o | output | LANES | Per-lane over-consume flag |

## Verification
The first refill from the empty state checks the dense case, where every lane requests and the addresses must run 0 to 31. Random consume amounts then leave the lanes with scattered counts. The following refills have sparse, irregular request masks, which show whether addresses come from a prefix rank rather than a fixed stride, and whether the pointer advances by the popcount. Directed steps separate three cases: inactive lanes with nonzero requests, an over-consume on one lane, and a consume issued together with a refill. In each case the state must stay unchanged where the rules say so.

// File: rtl/lane_refill_pkg.sv
package lane_refill_pkg;
    localparam int BUF_W  = 64;
    localparam int WORD_W = 32;
    localparam int CNT_W  = $clog2(BUF_W + 1);
    localparam int CON_W  = $clog2(BUF_W);

    typedef struct packed {
        logic [BUF_W-1:0] bits;
        logic [CNT_W-1:0] cnt;
        logic             uflow;
    } lane_state_t;
endpackage

// File: rtl/refill_rank.sv
module refill_rank #(
    parameter int LANES = 32,
    parameter int SUM_W = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0]       req_i,
    output logic [LANES*SUM_W-1:0] rank_o,
    output logic [SUM_W-1:0]       total_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_rank
        logic [SUM_W-1:0] acc;
        always_comb begin
            acc = '0;
            for (int j = 0; j < i; j++) begin
                acc = acc + SUM_W'(req_i[j]);
            end
        end
        assign rank_o[i*SUM_W +: SUM_W] = acc;
    end

    always_comb begin
        total_o = '0;
        for (int k = 0; k < LANES; k++) begin
            total_o = total_o + SUM_W'(req_i[k]);
        end
    end
endmodule

// File: rtl/lane_bitbuf.sv
module lane_bitbuf
    import lane_refill_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refill_go,
    input  logic              consume_go,
    input  logic              active_i,
    input  logic [CON_W-1:0]  consume_n_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              need_o,
    output logic [WORD_W-1:0] win_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              uflow_o
);
    lane_state_t st_d, st_q;

    assign need_o  = (st_q.cnt < CNT_W'(WORD_W));
    assign win_o   = st_q.bits[WORD_W-1:0];
    assign cnt_o   = st_q.cnt;
    assign uflow_o = st_q.uflow;

    always_comb begin
        st_d       = st_q;
        st_d.uflow = 1'b0;
        if (refill_go) begin
            if (need_o) begin
                st_d.bits = st_q.bits | (BUF_W'(word_i) << st_q.cnt);
                st_d.cnt  = st_q.cnt + CNT_W'(WORD_W);
            end
        end else if (consume_go && active_i) begin
            if (CNT_W'(consume_n_i) > st_q.cnt) begin
                st_d.uflow = 1'b1;
            end else begin
                st_d.bits = st_q.bits >> consume_n_i;
                st_d.cnt  = st_q.cnt - CNT_W'(consume_n_i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/lane_refill_unit.sv
module lane_refill_unit
    import lane_refill_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int ADDR_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      refill_go,
    input  logic                      consume_go,
    input  logic [LANES-1:0]          lane_active_i,
    input  logic [LANES*CON_W-1:0]    consume_n_i,
    input  logic [LANES*WORD_W-1:0]   rd_data_i,
    output logic [LANES-1:0]          rd_en_o,
    output logic [LANES*ADDR_W-1:0]   rd_addr_o,
    output logic [ADDR_W-1:0]         ptr_o,
    output logic [LANES*WORD_W-1:0]   win_o,
    output logic [LANES*CNT_W-1:0]    cnt_o,
    output logic [LANES-1:0]          underflow_o
);
    localparam int SUM_W = $clog2(LANES + 1);

    logic [LANES-1:0]       need;
    logic [LANES*SUM_W-1:0] rank;
    logic [SUM_W-1:0]       total;
    logic [ADDR_W-1:0]      ptr_d, ptr_q;

    refill_rank #(.LANES(LANES), .SUM_W(SUM_W)) u_rank (
        .req_i  (need),
        .rank_o (rank),
        .total_o(total)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_bitbuf u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .refill_go  (refill_go),
            .consume_go (consume_go),
            .active_i   (lane_active_i[i]),
            .consume_n_i(consume_n_i[i*CON_W +: CON_W]),
            .word_i     (rd_data_i[i*WORD_W +: WORD_W]),
            .need_o     (need[i]),
            .win_o      (win_o[i*WORD_W +: WORD_W]),
            .cnt_o      (cnt_o[i*CNT_W +: CNT_W]),
            .uflow_o    (underflow_o[i])
        );
        assign rd_addr_o[i*ADDR_W +: ADDR_W] = ptr_q + ADDR_W'(rank[i*SUM_W +: SUM_W]);
    end

    assign rd_en_o = refill_go ? need : '0;
    assign ptr_o   = ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (refill_go) begin
            ptr_d = ptr_q + ADDR_W'(total);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end
endmodule

// File: rtl/lane_refill_chk.sv
module lane_refill_chk
    import lane_refill_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int ADDR_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    refill_go,
    input logic                    consume_go,
    input logic [LANES-1:0]        rd_en_o,
    input logic [LANES*ADDR_W-1:0] rd_addr_o,
    input logic [ADDR_W-1:0]       ptr_o,
    input logic [LANES*CNT_W-1:0]  cnt_o,
    input logic [LANES-1:0]        underflow_o
);
    logic all_full;
    always_comb begin
        all_full = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (cnt_o[i*CNT_W +: CNT_W] < CNT_W'(WORD_W)) all_full = 1'b0;
        end
    end

    // R4
    ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_go |=> ptr_o == $past(ptr_o) + ADDR_W'($countones($past(rd_en_o))));

    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !refill_go |=> $stable(ptr_o));

    // R5
    full_after_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_go |=> all_full);

    // R3
    first_lane_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o[0] |-> rd_addr_o[ADDR_W-1:0] == ptr_o);

    // R8
    uflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_o != '0) |-> $past(consume_go && !refill_go));
endmodule

bind lane_refill_unit lane_refill_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .refill_go  (refill_go),
    .consume_go (consume_go),
    .rd_en_o    (rd_en_o),
    .rd_addr_o  (rd_addr_o),
    .ptr_o      (ptr_o),
    .cnt_o      (cnt_o),
    .underflow_o(underflow_o)
);

// File: tb/lane_refill_unit_bench.sv
module lane_refill_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 32;
    localparam int ADDR_W = 16;
    localparam int CON_W  = 6;
    localparam int CNT_W  = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic refill_go = 1'b0;
    logic consume_go = 1'b0;
    logic [LANES-1:0]        lane_active = '0;
    logic [LANES*CON_W-1:0]  consume_n = '0;
    logic [LANES*32-1:0]     rd_data;
    logic [LANES-1:0]        rd_en;
    logic [LANES*ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0]       ptr;
    logic [LANES*32-1:0]     win;
    logic [LANES*CNT_W-1:0]  cnt;
    logic [LANES-1:0]        uflow;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_bits [LANES];
    int          m_cnt  [LANES];
    int          m_ptr;
    logic [LANES-1:0] m_uf;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_refill_unit #(.LANES(LANES), .ADDR_W(ADDR_W)) u_lane_refill_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .refill_go    (refill_go),
        .consume_go   (consume_go),
        .lane_active_i(lane_active),
        .consume_n_i  (consume_n),
        .rd_data_i    (rd_data),
        .rd_en_o      (rd_en),
        .rd_addr_o    (rd_addr),
        .ptr_o        (ptr),
        .win_o        (win),
        .cnt_o        (cnt),
        .underflow_o  (uflow)
    );

    function automatic logic [31:0] mem_word(input logic [ADDR_W-1:0] a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h1234_5678;
    endfunction

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            rd_data[l*32 +: 32] = mem_word(rd_addr[l*ADDR_W +: ADDR_W]);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R1 R11 R8: compare the whole visible state with the model
    task automatic check_state(input string req);
        for (int l = 0; l < LANES; l++) begin
            chk(win[l*32 +: 32] == m_bits[l][31:0], {req, " R11 win"}, 64'(win[l*32 +: 32]), 64'(m_bits[l][31:0]));
            chk(int'(cnt[l*CNT_W +: CNT_W]) == m_cnt[l], {req, " R11 cnt"}, 64'(cnt[l*CNT_W +: CNT_W]), 64'(m_cnt[l]));
        end
        chk(int'(ptr) == m_ptr, {req, " R4 ptr"}, 64'(ptr), 64'(m_ptr));
        chk(uflow == m_uf, {req, " R8 uflow"}, 64'(uflow), 64'(m_uf));
    endtask

    // refill step; with_consume drives a consume in the same cycle (R9)
    task automatic do_refill(input bit with_consume, input bit first);
        logic [LANES-1:0] exp_mask;
        int rank;
        refill_go  = 1'b1;
        consume_go = with_consume;
        if (with_consume) begin
            lane_active = '1;
            for (int l = 0; l < LANES; l++) consume_n[l*CON_W +: CON_W] = 6'd5;
        end
        #1;
        rank = 0;
        for (int l = 0; l < LANES; l++) exp_mask[l] = (m_cnt[l] < 32);
        chk(rd_en == exp_mask, "R2 refill mask", 64'(rd_en), 64'(exp_mask));
        for (int l = 0; l < LANES; l++) begin
            if (exp_mask[l]) begin
                chk(int'(rd_addr[l*ADDR_W +: ADDR_W]) == m_ptr + rank,
                    first ? "R10 first-round address" : "R3 prefix address",
                    64'(rd_addr[l*ADDR_W +: ADDR_W]), 64'(m_ptr + rank));
                m_bits[l] = m_bits[l] | (64'(mem_word(ADDR_W'(m_ptr + rank))) << m_cnt[l]);
                m_cnt[l]  = m_cnt[l] + 32;
                rank++;
            end
        end
        m_ptr = (m_ptr + rank) % (1 << ADDR_W);
        m_uf  = '0;
        @(negedge clk);
        refill_go  = 1'b0;
        consume_go = 1'b0;
        lane_active = '0;
        consume_n  = '0;
        check_state(with_consume ? "R9 refill-and-consume" : (first ? "R10 first" : "R5 append"));
    endtask

    task automatic do_consume(input logic [LANES-1:0] act, input int n [LANES], input string req);
        consume_go  = 1'b1;
        lane_active = act;
        for (int l = 0; l < LANES; l++) consume_n[l*CON_W +: CON_W] = CON_W'(n[l]);
        m_uf = '0;
        for (int l = 0; l < LANES; l++) begin
            if (act[l]) begin
                if (n[l] > m_cnt[l]) begin
                    m_uf[l] = 1'b1;
                end else begin
                    m_bits[l] = m_bits[l] >> n[l];
                    m_cnt[l]  = m_cnt[l] - n[l];
                end
            end
        end
        @(negedge clk);
        consume_go  = 1'b0;
        lane_active = '0;
        consume_n   = '0;
        check_state(req);
    endtask

    initial begin
        int n [LANES];
        void'($urandom(32'd7));
        for (int l = 0; l < LANES; l++) begin
            m_bits[l] = '0;
            m_cnt[l]  = 0;
        end
        m_ptr = 0;
        m_uf  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_state("R1 reset");
        chk(rd_en == '0, "R1 no read", 64'(rd_en), 64'd0);

        do_refill(1'b0, 1'b1);

        // R8: lane 5 asks for 33 of its 32 bits
        for (int l = 0; l < LANES; l++) n[l] = 0;
        n[5] = 33;
        do_consume(32'h0000_0020, n, "R8 over-consume");
        // R8: flag lasts one cycle
        @(negedge clk);
        m_uf = '0;
        check_state("R8 flag clears");

        // R7: inactive lanes with large requests
        for (int l = 0; l < LANES; l++) n[l] = 20;
        do_consume(32'h0F0F_0F0F, n, "R7 inactive hold");

        // R9: refill together with consume
        do_refill(1'b1, 1'b0);

        // R6: random consume amounts
        for (int r = 0; r < 300; r++) begin
            logic [LANES-1:0] act;
            act = $urandom();
            if ((r % 5) == 0) act = '1;
            for (int l = 0; l < LANES; l++) begin
                if (($urandom() % 16) == 0) n[l] = m_cnt[l] + 1 + int'($urandom() % 4);
                else n[l] = int'($urandom() % 32);
                if (n[l] > 63) n[l] = 63;
            end
            do_consume(act, n, "R6 random consume");
            do_refill(1'b0, 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule